// File: doc/BRIEF.md
# Dual-Bank Ownership GPIO Controller

A controller for up to 32 general-purpose lines, reached through 32-bit word registers. Two complete register banks, a primary and a secondary, stand side by side. A per-line ownership word picks which bank drives each line's output value, its output enable and its interrupt flag logic. The primary bank can always be reached. The secondary bank and the ownership word can be reached only while an external permit input is high.

Pin inputs pass through a two-flop synchronizer. Interrupts are level-sensitive only. Each line has a programmable active level, set per bank. Each bank raises its own interrupt request from its flagged and unmasked lines. Software takes ownership first and then configures lines through the chosen bank. The out and direction values read back through a bank only show the lines that bank owns.

Register map (word index = byte offset / 4):
- Primary bank: 0 out, 1 dir, 2 in, 3 level, 4 flag, 5 mask, 6 mirror.
- Secondary bank: 7 enable, 8 out, 9 dir, 10 in, 11 level, 12 flag, 13 mask, 14 mirror.
- Ownership: 15.

Top module: `gpio_dual_bank`

## Requirements
- R1: While rst_ni is low, ownership is all zeros (every line secondary) and all other registers are cleared. rdata_o, pad_o, pad_oe_o, irq_pri_o and irq_sec_o are all 0 during reset.
- R2: For each line i, pad_o[i] is the primary out bit when ownership bit i is 1, and the secondary out bit when it is 0. pad_oe_o[i] is the primary dir bit for a primary line. For a secondary line it is the secondary dir bit ANDed with the secondary enable bit (word 7).
- R3: Out and dir reads return the stored bits masked by ownership: the primary bank (words 0, 1) shows bits whose ownership bit is 1, and the secondary bank (words 8, 9) shows bits whose ownership bit is 0.
- R4: The in and mirror words of both banks (2, 6, 10, 14) return the pins as they stood two clock edges earlier, for every line, whoever owns it.
- R5: A flag bit sets on every clock edge at which its line is owned by that bank and the synchronized pin equals the bank's level bit (1 = active high, 0 = active low). Lines owned by the other bank never set it.
- R6: Writing a flag word clears the bits written as 1 and leaves the bits written as 0. A bit whose condition still holds sets again at the same edge. All ones clears every inactive flag.
- R7: irq_pri_o / irq_sec_o is high exactly when the bank's flag word ANDed with its mask word is nonzero. A mask of zero keeps the request low.
- R8: While permit_i is low, reads of words 7 to 15 return 0 and writes to them are ignored. Primary words stay fully usable.
- R9: Registers sit at the word indices above. Level, mask and enable read back as written. rdata_o is 0 when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| permit_i | input | 1 | Allows access to secondary bank and ownership word |
| req_i | input | 1 | Register access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| waddr_i | input | 4 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the current request |
| pad_i | input | N | Pin input values |
| pad_o | output | N | Pin output values |
| pad_oe_o | output | N | Pin output enables |
| irq_pri_o | output | 1 | Primary bank interrupt request |
| irq_sec_o | output | 1 | Secondary bank interrupt request |

## Verification
The bench builds the block with N = 32 and SYNC_STAGES = 2. At this size every bit of each 32-bit word is a real line, so the all-ones flag clear and full-width ownership splits are exercised. It splits ownership between the lower and upper half-words, so the routing, the read masking and the flag gating of both banks are seen on the same pin patterns. It also toggles permit around writes to the secondary mask and the ownership word, to show the lock-out leaves the interrupt state untouched.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    SEL_OUT  = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_IN   = 3'd2,
    SEL_LVL  = 3'd3,
    SEL_FLAG = 3'd4,
    SEL_MASK = 3'd5,
    SEL_MIR  = 3'd6,
    SEL_EN   = 3'd7
  } bank_sel_e;

  localparam logic [3:0] W_PRI_LAST = 4'd6;
  localparam logic [3:0] W_SEC_EN   = 4'd7;
  localparam logic [3:0] W_SEC_LAST = 4'd14;
  localparam logic [3:0] W_OWNER    = 4'd15;
endpackage

// File: rtl/gpio_dual_sync.sv
module gpio_dual_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_dual_regs.sv
module gpio_dual_regs
  import gpio_dual_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter bit          HAS_EN = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  bank_sel_e sel_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] own_i,
  input  logic [N-1:0] sync_i,
  output logic [N-1:0] rdata_o,
  output logic [N-1:0] out_o,
  output logic [N-1:0] oe_o,
  output logic      irq_o
);
  logic [N-1:0] out_q, dir_q, lvl_q, flag_q, mask_q;
  logic [N-1:0] en_w, en_rd, set_w, clr_w;

  // level match on owned lines only
  assign set_w = own_i & ~(sync_i ^ lvl_q);
  assign clr_w = (wr_i && sel_i == SEL_FLAG) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_i) begin
        case (sel_i)
          SEL_OUT:  out_q  <= wdata_i;
          SEL_DIR:  dir_q  <= wdata_i;
          SEL_LVL:  lvl_q  <= wdata_i;
          SEL_MASK: mask_q <= wdata_i;
          default:  ;
        endcase
      end
      flag_q <= (flag_q & ~clr_w) | set_w;
    end
  end

  generate
    if (HAS_EN) begin : g_en
      logic [N-1:0] en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        en_q <= '0;
        else if (wr_i && sel_i == SEL_EN)   en_q <= wdata_i;
      end
      assign en_w  = en_q;
      assign en_rd = en_q;
    end else begin : g_no_en
      assign en_w  = '1;
      assign en_rd = '0;
    end
  endgenerate

  always_comb begin
    case (sel_i)
      SEL_OUT:         rdata_o = out_q & own_i;
      SEL_DIR:         rdata_o = dir_q & own_i;
      SEL_IN, SEL_MIR: rdata_o = sync_i;
      SEL_LVL:         rdata_o = lvl_q;
      SEL_FLAG:        rdata_o = flag_q;
      SEL_MASK:        rdata_o = mask_q;
      SEL_EN:          rdata_o = en_rd;
      default:         rdata_o = '0;
    endcase
  end

  assign out_o = out_q;
  assign oe_o  = dir_q & en_w;
  assign irq_o = |(flag_q & mask_q);

  // R5: a matching owned line is flagged at the next edge
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w != '0) |=> ((flag_q & $past(set_w)) == $past(set_w)));

  // R5: new flag bits only on lines owned at the previous edge
  p_unowned_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q) & ~$past(own_i)) == '0));

  // R6: cleared bits without a live condition read 0 afterwards
  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_FLAG) |=> ((flag_q & $past(wdata_i & ~set_w)) == '0));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned N           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          permit_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [3:0]    waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  pad_i,
  output logic [N-1:0]  pad_o,
  output logic [N-1:0]  pad_oe_o,
  output logic          irq_pri_o,
  output logic          irq_sec_o
);
  logic [N-1:0] sync_w, owner_q;
  logic [N-1:0] pri_rd, sec_rd, pri_out, sec_out, pri_oe, sec_oe;
  logic         rd_w, wr_w, pri_hit, sec_hit, own_hit;
  bank_sel_e    pri_sel, sec_sel;
  logic [N-1:0] rd_mux;

  assign rd_w    = req_i & ~we_i;
  assign wr_w    = req_i & we_i;
  assign pri_hit = (waddr_i <= W_PRI_LAST);
  assign sec_hit = (waddr_i >= W_SEC_EN) && (waddr_i <= W_SEC_LAST);
  assign own_hit = (waddr_i == W_OWNER);
  assign pri_sel = bank_sel_e'(waddr_i[2:0]);
  // words 8..14 map onto sel 0..6; word 7 is the enable word
  assign sec_sel = (waddr_i == W_SEC_EN) ? SEL_EN : bank_sel_e'(waddr_i[2:0]);

  gpio_dual_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (sync_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           owner_q <= '0;
    else if (wr_w && own_hit && permit_i)  owner_q <= wdata_i[N-1:0];
  end

  gpio_dual_regs #(.N(N), .HAS_EN(1'b0)) u_pri (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_w & pri_hit),
    .sel_i   (pri_sel),
    .wdata_i (wdata_i[N-1:0]),
    .own_i   (owner_q),
    .sync_i  (sync_w),
    .rdata_o (pri_rd),
    .out_o   (pri_out),
    .oe_o    (pri_oe),
    .irq_o   (irq_pri_o)
  );

  gpio_dual_regs #(.N(N), .HAS_EN(1'b1)) u_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_w & sec_hit & permit_i),
    .sel_i   (sec_sel),
    .wdata_i (wdata_i[N-1:0]),
    .own_i   (~owner_q),
    .sync_i  (sync_w),
    .rdata_o (sec_rd),
    .out_o   (sec_out),
    .oe_o    (sec_oe),
    .irq_o   (irq_sec_o)
  );

  assign pad_o    = (owner_q & pri_out) | (~owner_q & sec_out);
  assign pad_oe_o = (owner_q & pri_oe)  | (~owner_q & sec_oe);

  always_comb begin
    rd_mux = '0;
    if (rd_w) begin
      if (pri_hit)                   rd_mux = pri_rd;
      else if (permit_i && sec_hit)  rd_mux = sec_rd;
      else if (permit_i && own_hit)  rd_mux = owner_q;
    end
  end

  assign rdata_o = DW'(rd_mux);

  // R8: locked writes leave the ownership word alone
  p_owner_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_w && own_hit && !permit_i) |=> $stable(owner_q));

  // R8: locked reads of the secondary side return zero
  p_locked_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_w && !pri_hit && !permit_i) |-> (rdata_o == '0));
endmodule

// File: tb/gpio_dual_bank_tb.sv
`timescale 1ns/1ps
module gpio_dual_bank_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        permit = 1'b0, req = 1'b0, we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pad = '0, pad_o, pad_oe;
  logic        irq_p, irq_s;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_dual_bank #(.N(N), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .permit_i(permit), .req_i(req), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_pri_o(irq_p), .irq_sec_o(irq_s)
  );

  // behavioural reference state
  bit [31:0] m_s1, m_s2, m_own;
  bit [31:0] p_out, p_dir, p_lvl, p_flag, p_mask;
  bit [31:0] s_en, s_out, s_dir, s_lvl, s_flag, s_mask;
  bit [31:0] nf_p, nf_s;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_own, p_out, p_dir, p_lvl, p_flag, p_mask} = '0;
      {s_en, s_out, s_dir, s_lvl, s_flag, s_mask} = '0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        nf_p[i] = p_flag[i];
        nf_s[i] = s_flag[i];
        if (req && we && waddr == 4 && wdata[i]) nf_p[i] = 1'b0;
        if (req && we && waddr == 12 && permit && wdata[i]) nf_s[i] = 1'b0;
        if (m_own[i] == 1'b1 && m_s2[i] == p_lvl[i]) nf_p[i] = 1'b1;
        if (m_own[i] == 1'b0 && m_s2[i] == s_lvl[i]) nf_s[i] = 1'b1;
      end
      if (req && we) begin
        case (int'(waddr))
          0: p_out = wdata;
          1: p_dir = wdata;
          3: p_lvl = wdata;
          5: p_mask = wdata;
          default: ;
        endcase
        if (permit) begin
          case (int'(waddr))
            7: s_en = wdata;
            8: s_out = wdata;
            9: s_dir = wdata;
            11: s_lvl = wdata;
            13: s_mask = wdata;
            15: m_own = wdata;
            default: ;
          endcase
        end
      end
      p_flag = nf_p;
      s_flag = nf_s;
      m_s2 = m_s1;
      m_s1 = pad;
    end
  end

  function automatic bit [31:0] exp_rd();
    if (!(req && !we)) return 0;
    if (waddr >= 7 && !permit) return 0;
    case (int'(waddr))
      0: return p_out & m_own;
      1: return p_dir & m_own;
      2, 6, 10, 14: return m_s2;
      3: return p_lvl;
      4: return p_flag;
      5: return p_mask;
      7: return s_en;
      8: return s_out & ~m_own;
      9: return s_dir & ~m_own;
      11: return s_lvl;
      12: return s_flag;
      13: return s_mask;
      default: return m_own;
    endcase
  endfunction

  function automatic string rd_tag();
    if (!(req && !we)) return "R9";
    if (waddr >= 7 && !permit) return "R8";
    case (int'(waddr))
      0, 1, 8, 9: return "R3";
      2, 6, 10, 14: return "R4";
      4, 12: return "R5 R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s @%0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", "rdata", rdata, 0);
        chk("R1", "pad_o", pad_o, 0);
        chk("R1", "pad_oe", pad_oe, 0);
        chk("R1", "irqs", {30'd0, irq_p, irq_s}, 0);
      end else begin
        chk("R2", "pad_o", pad_o, (m_own & p_out) | (~m_own & s_out));
        chk("R2", "pad_oe", pad_oe, (m_own & p_dir) | (~m_own & s_dir & s_en));
        chk("R7", "irq_pri", {31'd0, irq_p}, {31'd0, |(p_flag & p_mask)});
        chk("R7", "irq_sec", {31'd0, irq_s}, {31'd0, |(s_flag & s_mask)});
        chk(rd_tag(), "rdata", rdata, exp_rd());
      end
    end
  end

  task automatic op(input bit r, input bit w, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    req = r; we = w; waddr = a; wdata = d;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); op(1, 1, a, d); endtask
  task automatic rd(input logic [3:0] a); op(1, 0, a, '0); endtask
  task automatic idle(); op(0, 0, '0, '0); endtask
  task automatic set_pad(input logic [31:0] v); idle(); pad = v; endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R8: locked secondary side
    rd(15); rd(8); rd(12); rd(7);
    wr(15, 32'hFFFF_0000); wr(13, 32'hFFFF_FFFF);
    permit = 1'b1;
    rd(15); rd(13); rd(12);
    // R2 R3: split ownership
    wr(15, 32'h0000_FFFF);
    wr(0, 32'hAAAA_AAAA); wr(1, 32'hFFFF_FFFF);
    wr(8, 32'h5555_5555); wr(9, 32'hFFFF_FFFF); wr(7, 32'h0F0F_0000);
    rd(0); rd(1); rd(8); rd(9); rd(7); rd(15);
    // R4: synchronized pins
    set_pad(32'h1234_5678); rd(2); rd(6); rd(10); rd(14); idle(); rd(2); rd(14);
    // R5 R6: levels and write-one-to-clear
    wr(3, 32'h0000_FFFF); wr(11, 32'hFFFF_0000);
    wr(4, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); rd(4); rd(12);
    set_pad(32'h0000_0000); idle(); idle();
    wr(4, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); rd(4); rd(12); rd(3); rd(11);
    // R7: masks
    wr(5, 32'h0000_00FF); wr(13, 32'h00FF_0000);
    set_pad(32'h00F0_00F0); idle(); idle(); rd(4); rd(12);
    set_pad(32'h0000_0000);
    wr(4, 32'h0000_0000); rd(4);
    wr(4, 32'h0000_0010); rd(4);
    wr(4, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); idle(); rd(4); rd(12);
    set_pad(32'h0001_0002); idle(); idle(); rd(4); rd(12);
    // R8: lock-out keeps interrupt state
    permit = 1'b0;
    wr(13, 32'h0000_0000); wr(15, 32'h0000_0000); wr(12, 32'hFFFF_FFFF);
    rd(13); rd(5); wr(5, 32'h0000_0000); rd(5);
    permit = 1'b1;
    rd(13); rd(15); rd(12);
    wr(13, 32'h0000_0000); idle();
    // walking pins under both owners
    wr(3, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      set_pad(32'h1 << (k * 4));
      idle(); rd(2); wr(4, 32'hFFFF_FFFF); rd(4);
    end
    wr(15, 32'hFFFF_FFFF); rd(0); rd(8); rd(9); idle(); idle();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule